// File: doc/BRIEF.md
# Shared-Function Port with Serial-Interface Override

This block controls a seven-line general-purpose port whose pins are also used by a serial peripheral interface (SPI) engine and by a timer oscillator. Software uses a small register bus to write an output data latch and a direction register. The port then decides, line by line, whether each pin is driven and with what value. Lines 2 to 5 are bidirectional. Lines 0 and 1 are inputs, except that line 1 becomes an oscillator drive pin once the timer oscillator has been started. Line 7 is always an input. Bit position 6 has no pin.

When the SPI engine is enabled, its master or slave role takes over lines 2 to 5. Line 2 carries slave-out data, line 3 master-out data, line 4 the serial clock and line 5 the select or mode-fault sense. A line the engine needs as an input is forced to input. A line the engine wants to drive is driven only if software has also set its direction bit. A wired-OR control makes driven lines 2 to 5 open-drain. The oscillator takeover of line 1 is held by a two-state machine: IDLE moves to RUNNING on the ARM transition (the enable is seen high at a clock edge), and RUNNING holds until reset.

Top module: `spi_shared_port`

## Requirements
- R1: After reset, the direction register reads 0x00, pin_oe is 0x00 on every line, and osc_active is 0.
- R2: Register select 1 addresses the direction register and select 0 the data register. Writes to direction bits 0, 1, 6 and 7 are discarded, and those bits always read 0.
- R3: With spi_en low, each line k in 2..5 is driven exactly when direction bit k is 1, and it drives data latch bit k. In every mode, pin_out is 0 on any line whose pin_oe is 0.
- R4: In master mode (spi_en=1, spi_master=1), line 2 is an input whatever its direction bit. Lines 3 and 4 drive spi_mosi_out and spi_sck_out only when their direction bits are 1. spi_din follows pin 2.
- R5: In slave mode (spi_en=1, spi_master=0), lines 3, 4 and 5 are inputs whatever their direction bits. Line 2 drives spi_miso_out only when direction bit 2 is 1. spi_din follows pin 3, spi_sck_in follows pin 4, and spi_ss_n follows pin 5.
- R6: In master mode, line 5 with direction bit 0 is an input and spi_fault_n follows pin 5. With direction bit 1, line 5 drives data latch bit 5 and spi_fault_n is 1. spi_ss_n is 1 outside slave mode, and spi_fault_n is 1 outside master mode.
- R7: Line 0 is never driven. Line 1 is an input until tosc_en is seen high at a clock edge. From the next cycle until reset, osc_active is 1 and line 1 drives tosc_drive, even if tosc_en falls.
- R8: With wired_or set, a line in 2..5 that resolves to output asserts pin_oe only when its value is 0 (pin_out 0). A value of 1 releases the line.
- R9: A data-register read of a line in 2..5 returns latch bit k when the line resolves to output, including an output released by wired-OR. Otherwise it returns pin_in bit k. Bits 0 and 7 return the pin level.
- R10: Data-register bit 6 always reads 0, and line 6 is never driven. Data bit 1 reads 0 while osc_active is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the data register, 1 selects the direction register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| spi_en | input | 1 | SPI engine enabled |
| spi_master | input | 1 | 1 selects master role, 0 selects slave role |
| spi_miso_out | input | 1 | Slave-out data from the engine |
| spi_mosi_out | input | 1 | Master-out data from the engine |
| spi_sck_out | input | 1 | Serial clock from the engine (master) |
| spi_din | output | 1 | Serial data into the engine |
| spi_sck_in | output | 1 | Serial clock into the engine (slave) |
| spi_ss_n | output | 1 | Slave select into the engine |
| spi_fault_n | output | 1 | Mode-fault sense into the engine |
| tosc_en | input | 1 | Timer oscillator start request |
| tosc_drive | input | 1 | Oscillator drive value for line 1 |
| osc_active | output | 1 | Latched oscillator state |
| wired_or | input | 1 | Open-drain mode for lines 2 to 5 |
| pin_in | input | 8 | Pin levels |
| pin_oe | output | 8 | Per-line driver enable |
| pin_out | output | 8 | Per-line drive value |

## Verification
A wrong resolved direction shows at pin_oe and in the data read-back in the same cycle as the mode or register change, because both paths are combinational from the registers. A stuck or wrongly cleared oscillator state shows on line 1 and osc_active one cycle after the request edge, and at every later cycle until reset. A latch or direction bit written to the wrong place shows on the next read or drive after the write edge. The bench sweeps every direction value under every SPI role and wired-OR setting, with several latch and pin patterns.

// File: rtl/sp_port_pkg.sv
package sp_port_pkg;
    localparam int unsigned PORT_LINES = 8;
    localparam int unsigned BIDIR_LO   = 2;
    localparam int unsigned BIDIR_HI   = 5;
    localparam int unsigned LINE_SDO_S = 2;   // slave data out / master data in
    localparam int unsigned LINE_SDO_M = 3;   // master data out / slave data in
    localparam int unsigned LINE_CLK   = 4;
    localparam int unsigned LINE_SEL   = 5;
    localparam int unsigned OSC_LINE   = 1;
    localparam int unsigned NO_PIN     = 6;

    typedef enum logic {
        OSC_IDLE    = 1'b0,
        OSC_RUNNING = 1'b1
    } osc_state_e;

    typedef enum logic [1:0] {
        MODE_GPIO   = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_SLAVE  = 2'd2
    } port_mode_e;
endpackage

// File: rtl/sp_port_regs.sv
module sp_port_regs #(
    parameter int unsigned LINES = 8,
    parameter int unsigned LO    = 2,
    parameter int unsigned HI    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] data_q,
    output logic [LINES-1:0] dir_q
);
    localparam logic [LINES-1:0] KEEP_MASK =
        LINES'(((1 << (HI - LO + 1)) - 1) << LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (reg_sel) dir_q  <= wdata & KEEP_MASK;
            else         data_q <= wdata & KEEP_MASK;
        end
    end
endmodule

// File: rtl/sp_osc_latch.sv
module sp_osc_latch
    import sp_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_req,
    output logic osc_on
);
    osc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OSC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OSC_IDLE:    if (osc_req) state_d = OSC_RUNNING;   // ARM
            OSC_RUNNING: state_d = OSC_RUNNING;                // HOLD
            default:     state_d = OSC_IDLE;
        endcase
    end

    always_comb begin
        osc_on = 1'b0;
        unique case (state_q)
            OSC_IDLE:    osc_on = 1'b0;
            OSC_RUNNING: osc_on = 1'b1;
            default:     osc_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/sp_line_mux.sv
module sp_line_mux
    import sp_port_pkg::*;
#(
    parameter int unsigned IDX = 2
) (
    input  port_mode_e mode,
    input  logic       dir_bit,
    input  logic       latch_bit,
    input  logic       eng_val,
    input  logic       wired_or,
    input  logic       pin_lvl,
    output logic       oe,
    output logic       drv,
    output logic       rd_bit
);
    logic is_out;
    logic val;

    always_comb begin
        is_out = dir_bit;
        val    = latch_bit;
        unique case (mode)
            MODE_GPIO: begin
                is_out = dir_bit;
                val    = latch_bit;
            end
            MODE_MASTER: begin
                if (IDX == LINE_SDO_S) begin
                    is_out = 1'b0;
                end else if (IDX == LINE_SDO_M || IDX == LINE_CLK) begin
                    is_out = dir_bit;
                    val    = eng_val;
                end else begin
                    is_out = dir_bit;
                end
            end
            MODE_SLAVE: begin
                if (IDX == LINE_SDO_S) begin
                    is_out = dir_bit;
                    val    = eng_val;
                end else begin
                    is_out = 1'b0;
                end
            end
            default: is_out = 1'b0;
        endcase
    end

    assign oe     = is_out & ~(wired_or & val);
    assign drv    = oe & val;
    assign rd_bit = is_out ? latch_bit : pin_lvl;
endmodule

// File: rtl/spi_shared_port.sv
module spi_shared_port
    import sp_port_pkg::*;
#(
    parameter int unsigned LINES = PORT_LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic             spi_en,
    input  logic             spi_master,
    input  logic             spi_miso_out,
    input  logic             spi_mosi_out,
    input  logic             spi_sck_out,
    output logic             spi_din,
    output logic             spi_sck_in,
    output logic             spi_ss_n,
    output logic             spi_fault_n,
    input  logic             tosc_en,
    input  logic             tosc_drive,
    output logic             osc_active,
    input  logic             wired_or,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] pin_oe,
    output logic [LINES-1:0] pin_out
);
    logic [LINES-1:0] data_q, dir_q, data_rd, eng_vals;
    port_mode_e       mode;

    sp_port_regs #(.LINES(LINES), .LO(BIDIR_LO), .HI(BIDIR_HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .data_q(data_q), .dir_q(dir_q)
    );

    sp_osc_latch u_osc (
        .clk(clk), .rst_n(rst_n), .osc_req(tosc_en), .osc_on(osc_active)
    );

    always_comb begin
        if (!spi_en)        mode = MODE_GPIO;
        else if (spi_master) mode = MODE_MASTER;
        else                 mode = MODE_SLAVE;
    end

    always_comb begin
        eng_vals             = '0;
        eng_vals[LINE_SDO_S] = spi_miso_out;
        eng_vals[LINE_SDO_M] = spi_mosi_out;
        eng_vals[LINE_CLK]   = spi_sck_out;
    end

    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (k >= BIDIR_LO && k <= BIDIR_HI) begin : g_bidir
            sp_line_mux #(.IDX(k)) u_mux (
                .mode(mode), .dir_bit(dir_q[k]), .latch_bit(data_q[k]),
                .eng_val(eng_vals[k]), .wired_or(wired_or), .pin_lvl(pin_in[k]),
                .oe(pin_oe[k]), .drv(pin_out[k]), .rd_bit(data_rd[k])
            );
        end else if (k == OSC_LINE) begin : g_osc
            assign pin_oe[k]  = osc_active;
            assign pin_out[k] = osc_active & tosc_drive;
            assign data_rd[k] = ~osc_active & pin_in[k];
        end else if (k == NO_PIN) begin : g_none
            assign pin_oe[k]  = 1'b0;
            assign pin_out[k] = 1'b0;
            assign data_rd[k] = 1'b0;
        end else begin : g_input
            assign pin_oe[k]  = 1'b0;
            assign pin_out[k] = 1'b0;
            assign data_rd[k] = pin_in[k];
        end
    end

    assign rdata = reg_sel ? dir_q : data_rd;

    always_comb begin
        spi_din     = 1'b0;
        spi_sck_in  = 1'b0;
        spi_ss_n    = 1'b1;
        spi_fault_n = 1'b1;
        unique case (mode)
            MODE_GPIO: ;
            MODE_MASTER: begin
                spi_din = pin_in[LINE_SDO_S];
                if (!dir_q[LINE_SEL]) spi_fault_n = pin_in[LINE_SEL];
            end
            MODE_SLAVE: begin
                spi_din    = pin_in[LINE_SDO_M];
                spi_sck_in = pin_in[LINE_CLK];
                spi_ss_n   = pin_in[LINE_SEL];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sp_port_checker.sv
module sp_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       reg_sel,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       spi_en,
    input logic       spi_master,
    input logic       spi_ss_n,
    input logic       spi_fault_n,
    input logic       tosc_en,
    input logic       tosc_drive,
    input logic       osc_active,
    input logic       wired_or,
    input logic [7:0] pin_oe,
    input logic [7:0] pin_out
);
    assert_dir_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (rdata[7:6] == 2'b00 && rdata[1:0] == 2'b00));

    assert_master_line2_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> !pin_oe[2]);

    assert_slave_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (pin_oe[5:3] == 3'b000));

    assert_ss_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(spi_en && !spi_master) |-> spi_ss_n);

    assert_osc_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tosc_en |=> osc_active);

    assert_osc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_active |=> osc_active);

    assert_osc_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_active |-> (pin_oe[1] && pin_out[1] == tosc_drive));

    assert_line0_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[0]);

    assert_wom_low_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wired_or |-> ((pin_oe[5:2] & pin_out[5:2]) == 4'b0000));

    assert_released_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_oe) & pin_out) == 8'h00);

    assert_no_pin6_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[6] && !pin_oe[7]);
endmodule

bind spi_shared_port sp_port_checker u_chk (.*);

// File: tb/tb_spi_shared_port.sv
module tb_spi_shared_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       spi_en = 1'b0, spi_master = 1'b0;
    logic       spi_miso_out = 1'b0, spi_mosi_out = 1'b0, spi_sck_out = 1'b0;
    logic       spi_din, spi_sck_in, spi_ss_n, spi_fault_n;
    logic       tosc_en = 1'b0, tosc_drive = 1'b0, osc_active;
    logic       wired_or = 1'b0;
    logic [7:0] pin_in = '0, pin_oe, pin_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_shared_port dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; reg_sel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pin_in = 8'hC3;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        reg_sel = 1'b1; #1;
        chk("R1 dir after reset", rdata, 8'h00);
        chk("R1 oe after reset", pin_oe, 8'h00);
        chk("R1 osc after reset", {7'd0, osc_active}, 8'h00);
        reg_sel = 1'b0; #1;
        chk("R10 data read bit6 zero", rdata, 8'h83);

        // R2 direction masking
        wr(1'b1, 8'hFF);
        reg_sel = 1'b1; #1;
        chk("R2 dir write all ones", rdata, 8'h3C);
        reg_sel = 1'b0;
        wr(1'b1, 8'hC3);
        reg_sel = 1'b1; #1;
        chk("R2 dir write unused bits", rdata, 8'h00);
        chk("R2 no drive", pin_oe, 8'h00);
        reg_sel = 1'b0;

        // Sweep over role, wired-OR, direction and patterns
        for (int md = 0; md < 8; md++) begin
            for (int d = 0; d < 16; d++) begin
                for (int p = 0; p < 4; p++) begin
                    logic en, ms, w;
                    logic [3:0] lat, pn;
                    logic [7:0] e_oe, e_out, e_rd;
                    logic e_din, e_sck, e_ss, e_flt;
                    string tg;
                    en = md[0]; ms = md[1]; w = md[2];
                    lat = 4'((p * 7 + 5) & 15);
                    pn  = ~lat ^ 4'(p);
                    wr(1'b0, {2'b00, lat, 2'b00});
                    wr(1'b1, {2'b00, 4'(d), 2'b00});
                    spi_en = en; spi_master = ms; wired_or = w;
                    spi_miso_out = p[0]; spi_mosi_out = p[1]; spi_sck_out = p[0] ^ p[1];
                    pin_in = {p[0], 1'b1, pn, p[1], 1'b0};
                    e_oe = '0; e_out = '0;
                    e_rd = {p[0], 1'b0, 4'b0000, p[1], 1'b0};
                    for (int k = 2; k <= 5; k++) begin
                        logic dir_e, val;
                        dir_e = d[k-2];
                        val   = lat[k-2];
                        if (en && ms) begin
                            if (k == 2) dir_e = 1'b0;
                            if (k == 3) val = p[1];
                            if (k == 4) val = p[0] ^ p[1];
                        end else if (en) begin
                            if (k != 2) dir_e = 1'b0;
                            else        val = p[0];
                        end
                        e_oe[k]  = dir_e && !(w && val);
                        e_out[k] = e_oe[k] && val;
                        e_rd[k]  = dir_e ? lat[k-2] : pn[k-2];
                    end
                    e_din = en ? (ms ? pn[0] : pn[1]) : 1'b0;
                    e_sck = (en && !ms) ? pn[2] : 1'b0;
                    e_ss  = (en && !ms) ? pn[3] : 1'b1;
                    e_flt = (en && ms && !d[3]) ? pn[3] : 1'b1;
                    tg = w ? "R8" : (!en ? "R3" : (ms ? "R4/R6" : "R5"));
                    #1;
                    chk($sformatf("%s oe md=%0d d=%0d p=%0d", tg, md, d, p), pin_oe, e_oe);
                    chk($sformatf("%s out md=%0d d=%0d p=%0d", tg, md, d, p), pin_out, e_out);
                    chk($sformatf("R9 read md=%0d d=%0d p=%0d", md, d, p), rdata, e_rd);
                    chk($sformatf("R5/R6 engine ins md=%0d d=%0d p=%0d", md, d, p),
                        {4'd0, e_din, e_sck, e_ss, e_flt},
                        {4'd0, e_din, e_sck, e_ss, e_flt} ^
                        {4'd0, spi_din ^ e_din, spi_sck_in ^ e_sck, spi_ss_n ^ e_ss, spi_fault_n ^ e_flt});
                end
            end
        end

        // R7 oscillator latch
        spi_en = 1'b0; wired_or = 1'b0;
        wr(1'b1, 8'h00);
        pin_in = 8'h02;
        #1;
        chk("R7 line1 input before arm", {6'd0, pin_oe[1:0]}, 8'h00);
        chk("R10 bit1 reads pin before arm", rdata & 8'h02, 8'h02);
        @(negedge clk); tosc_en = 1'b1;
        @(negedge clk); tosc_en = 1'b0; tosc_drive = 1'b1;
        #1;
        chk("R7 osc active", {7'd0, osc_active}, 8'h01);
        chk("R7 line1 drives one", {6'd0, pin_oe[1], pin_out[1]}, 8'h03);
        chk("R10 bit1 reads zero when osc", rdata & 8'h02, 8'h00);
        repeat (3) @(negedge clk);
        tosc_drive = 1'b0; #1;
        chk("R7 osc still held", {6'd0, osc_active, pin_oe[1]}, 8'h03);
        chk("R7 line1 drives zero", {7'd0, pin_out[1]}, 8'h00);
        chk("R7 line0 never driven", {7'd0, pin_oe[0]}, 8'h00);
        rst_n = 1'b0; #1;
        chk("R1 reset clears osc", {6'd0, osc_active, pin_oe[1]}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule